// File: doc/BRIEF.md
# Transfer Request List Sequencer

This block walks a descriptor made of a header slot followed by a list of equal-sized transfer request records. The header fields arrive on input ports and are captured by a start pulse. For each record, the sequencer reads two words through a simple memory request port. The first word holds the record's flags and the second holds its innermost count in the low half. The sequencer then screens the record. A record that passes is offered to a downstream transfer engine over a valid/ready handshake. A record that fails is answered at once with an error response.

The engine reports completions in issue order on a second valid/ready channel. Up to `OUT_DEPTH` records may be in flight at once, unless a record asks to be waited on. Every record visit leaves a 32-bit response word in a response area placed after the last record. After the last record the walk can jump back to a reload index a fixed number of times, or without end. When the walk ends and every response has been written, the block gives a one-cycle done pulse with an error summary.

The controller has these states. IDLE waits for start. GATE decides what comes next. RD_FLAGS and RD_CNT fetch the two record words. CHECK screens the record. ISSUE hands the record to the engine. REJ_WR writes an error response. CPL_WR writes a completion response. STEP advances or reloads the index. DRAIN waits for the outstanding completions. DONE raises the pulse.

The transitions are as follows:
- IDLE→GATE on start.
- GATE→CPL_WR when a completion is held. GATE→RD_FLAGS when neither the wait rule nor a full tag queue blocks the walk. Otherwise GATE stays in GATE.
- RD_FLAGS→RD_CNT→CHECK, each on a memory grant.
- CHECK→REJ_WR or CHECK→ISSUE.
- ISSUE→STEP on ready. REJ_WR→STEP on grant.
- STEP→GATE while records remain, otherwise STEP→DRAIN.
- CPL_WR→GATE or CPL_WR→DRAIN on grant.
- DRAIN→CPL_WR when a completion is held, or DRAIN→DONE once nothing is outstanding.
- DONE→IDLE.

Top module: `tq_seq`

## Requirements
- R1: After reset, `tr_valid`, `mem_req`, `cpl_ready` and `done` are low.
- R2: The record size is 16 << code, where code is `hdr_rec_size`; codes above 3 select 128 bytes. Record i starts at base + (i+1)*size. Its flags word is read from that address and its innermost count from bits 15:0 of the word at the address plus 4. The engine receives the record address, flags, count and index, all held stable until `tr_ready`.
- R3: The response for record i is written at base + (last+2)*size + 4*i. Its layout is: bits 3:0 status type, bits 7:4 status info, bits 23:16 the record's command ID (flag bits 23:16), and all other bits zero.
- R4: Records are visited from 0 up to `hdr_last_idx`. After the last record, while the remaining reload count is nonzero, the walk jumps to `hdr_reload_idx` and continues. Each jump lowers the count by one. A count of 0 ends the walk.
- R5: A reload count of 0x1FF never decrements, so the walk repeats without end and no done pulse is given.
- R6: A record whose type (flag bits 3:0) has a clear bit in `TYPE_MASK` is not issued. Its response type is 4 with info 0. This check wins over R7.
- R7: A record whose innermost count is zero is not issued. Its response type is 3 with info 0.
- R8: When an issued record has flag bit 5 set, the next record is not issued until that record's completion has been accepted.
- R9: At most `OUT_DEPTH` records are outstanding. Completions are matched to records in issue order. A completion response carries the engine's 8-bit status in bits 7:0.
- R10: `done` is a one-cycle pulse given after the last response write. `done_err` is high with it exactly when some response written in the walk had a nonzero type.
- R11: `start` and the header inputs are ignored from the first step of the walk until the done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a walk (sampled in IDLE) |
| desc_base | input | AW | Descriptor base byte address |
| hdr_last_idx | input | 14 | Record count minus one |
| hdr_reload_idx | input | 6 | Index to resume from on a jump |
| hdr_reload_cnt | input | 9 | Number of jumps; 0x1FF means endless |
| hdr_rec_size | input | 3 | Record size code |
| mem_req | output | 1 | Memory request, held until granted |
| mem_we | output | 1 | 1 means write, 0 means read |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Request accepted; read data valid |
| mem_rdata | input | 32 | Read data |
| tr_valid | output | 1 | Record offered to engine |
| tr_ready | input | 1 | Engine accepts record |
| tr_addr | output | AW | Record byte address |
| tr_flags | output | 32 | Record flags word |
| tr_icnt0 | output | 16 | Innermost count |
| tr_idx | output | 14 | Record index |
| cpl_valid | input | 1 | Engine completion offered |
| cpl_ready | output | 1 | Completion accepted |
| cpl_status | input | 8 | Completion status (type low, info high) |
| done | output | 1 | Walk finished pulse |
| done_err | output | 1 | Some response had a nonzero type |

## Verification
A record handoff, a memory access and a completion each take effect at the clock edge where both sides of the handshake are high. The bench sets `tr_ready`, `mem_gnt` and `cpl_valid` at the falling edge. At that same falling edge it reads the design's registered `tr_valid`, `mem_req` and `cpl_ready`, so it knows which transfers the next rising edge will commit and checks issue order, addresses, the wait rule and the outstanding count there. `done` comes two to three cycles after the grant of the final response write. The bench therefore waits for the pulse and only then compares the response area, the issue count and the error bit against values it derives from the header and the record contents. The endless-loop case is checked over a fixed number of visits before a reset stops it.

// File: rtl/tq_pkg.sv
package tq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_GATE,
        ST_RD_FLAGS,
        ST_RD_CNT,
        ST_CHECK,
        ST_ISSUE,
        ST_REJ_WR,
        ST_STEP,
        ST_CPL_WR,
        ST_DRAIN,
        ST_DONE
    } tq_state_e;

    // response status types (low nibble of the status byte)
    localparam logic [3:0] RSP_COMPLETE = 4'd0;
    localparam logic [3:0] RSP_XFER_ERR = 4'd1;
    localparam logic [3:0] RSP_ABORTED  = 4'd2;
    localparam logic [3:0] RSP_SUBMIT   = 4'd3;
    localparam logic [3:0] RSP_UNSUP    = 4'd4;

    // flag word field positions decoded by this block
    localparam int FLG_WAIT_BIT = 5;
    localparam int FLG_CMD_LSB  = 16;

    function automatic logic [31:0] rsp_word(input logic [7:0] cmd, input logic [7:0] stat);
        return {8'h00, cmd, 8'h00, stat};
    endfunction

endpackage

// File: rtl/tq_addr_gen.sv
module tq_addr_gen #(
    parameter int AW    = 32,
    parameter int IDX_W = 14
) (
    input  logic [AW-1:0]    base,
    input  logic [2:0]       size_code,
    input  logic [IDX_W-1:0] last_idx,
    input  logic [IDX_W-1:0] rec_idx,
    input  logic [IDX_W-1:0] rsp_idx,
    output logic [AW-1:0]    rec_addr,
    output logic [AW-1:0]    rsp_addr
);
    localparam int SH_W = 3;

    logic [SH_W-1:0] shamt;
    logic [AW-1:0]   rec_slot;
    logic [AW-1:0]   rsp_slot;

    always_comb begin
        // codes above 3 saturate at the largest record size
        shamt    = (size_code > 3'd3) ? 3'd7 : (3'd4 + size_code);
        rec_slot = AW'(rec_idx) + AW'(1);
        rsp_slot = AW'(last_idx) + AW'(2);
        rec_addr = base + (rec_slot << shamt);
        rsp_addr = base + (rsp_slot << shamt) + (AW'(rsp_idx) << 2);
    end
endmodule

// File: rtl/tq_loop_ctl.sv
module tq_loop_ctl #(
    parameter int IDX_W  = 14,
    parameter int RIDX_W = 6,
    parameter int RCNT_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [IDX_W-1:0]  last_idx,
    input  logic [RIDX_W-1:0] reload_idx,
    input  logic [RCNT_W-1:0] reload_cnt,
    output logic [IDX_W-1:0]  cur_idx,
    output logic              more
);
    localparam logic [RCNT_W-1:0] CNT_ENDLESS = '1;

    logic [IDX_W-1:0]  idx_q;
    logic [RCNT_W-1:0] left_q;
    logic              at_last;

    always_comb begin
        at_last = (idx_q == last_idx);
        more    = !at_last || (left_q != '0);
        cur_idx = idx_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= '0;
            left_q <= '0;
        end else if (load) begin
            idx_q  <= '0;
            left_q <= reload_cnt;
        end else if (step) begin
            if (!at_last) begin
                idx_q <= idx_q + IDX_W'(1);
            end else if (left_q != '0) begin
                idx_q <= IDX_W'(reload_idx);
                if (left_q != CNT_ENDLESS) begin
                    left_q <= left_q - RCNT_W'(1);
                end
            end
        end
    end

    AST_ENDLESS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && left_q == CNT_ENDLESS) |=> (left_q == CNT_ENDLESS)); // R5

    AST_JUMP_TO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && at_last && left_q != '0) |=> (idx_q == IDX_W'($past(reload_idx)))); // R4

    AST_COUNT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && at_last && left_q != '0 && left_q != CNT_ENDLESS)
        |=> (left_q == $past(left_q) - RCNT_W'(1))); // R4
endmodule

// File: rtl/tq_tag_fifo.sv
module tq_tag_fifo #(
    parameter int W     = 22,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     slot_q [DEPTH];
    logic [PTR_W-1:0] wr_q;
    logic [PTR_W-1:0] rd_q;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        empty = (cnt_q == '0);
        full  = (cnt_q == CNT_W'(DEPTH));
        dout  = slot_q[rd_q];
    end

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_slot
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    slot_q[g] <= '0;
                end else if (push && wr_q == PTR_W'(g)) begin
                    slot_q[g] <= din;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) wr_q <= ptr_inc(wr_q);
            if (pop)  rd_q <= ptr_inc(rd_q);
            if (push && !pop)      cnt_q <= cnt_q + CNT_W'(1);
            else if (pop && !push) cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full); // R9

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty); // R9
endmodule

// File: rtl/tq_seq.sv
module tq_seq #(
    parameter int          AW        = 32,
    parameter int          IDX_W     = 14,
    parameter int          RIDX_W    = 6,
    parameter int          RCNT_W    = 9,
    parameter int          OUT_DEPTH = 4,
    parameter logic [15:0] TYPE_MASK = 16'h000F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [AW-1:0]     desc_base,
    input  logic [IDX_W-1:0]  hdr_last_idx,
    input  logic [RIDX_W-1:0] hdr_reload_idx,
    input  logic [RCNT_W-1:0] hdr_reload_cnt,
    input  logic [2:0]        hdr_rec_size,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_gnt,
    input  logic [31:0]       mem_rdata,
    output logic              tr_valid,
    input  logic              tr_ready,
    output logic [AW-1:0]     tr_addr,
    output logic [31:0]       tr_flags,
    output logic [15:0]       tr_icnt0,
    output logic [IDX_W-1:0]  tr_idx,
    input  logic              cpl_valid,
    output logic              cpl_ready,
    input  logic [7:0]        cpl_status,
    output logic              done,
    output logic              done_err
);
    import tq_pkg::*;

    localparam int TAG_W = IDX_W + 8;

    tq_state_e state_q, state_d;

    logic [AW-1:0]     base_q;
    logic [2:0]        code_q;
    logic [IDX_W-1:0]  last_q;
    logic [RIDX_W-1:0] rl_idx_q;
    logic [31:0]       flags_q;
    logic [15:0]       icnt_q;
    logic              hold_wait_q;
    logic              pend_q;
    logic [7:0]        pend_stat_q;
    logic [IDX_W-1:0]  pend_idx_q;
    logic [7:0]        pend_cmd_q;
    logic              err_q;
    logic              drain_q;

    logic              load, step, more;
    logic [IDX_W-1:0]  cur_idx;
    logic [AW-1:0]     rec_addr, rsp_addr;
    logic [IDX_W-1:0]  rsp_idx;
    logic              fifo_push, fifo_pop, fifo_empty, fifo_full;
    logic [TAG_W-1:0]  fifo_dout;
    logic              type_bad, cnt_zero;
    logic [7:0]        rej_stat;

    assign load = (state_q == ST_IDLE) && start;
    assign step = (state_q == ST_STEP);

    tq_loop_ctl #(.IDX_W(IDX_W), .RIDX_W(RIDX_W), .RCNT_W(RCNT_W)) u_loop (
        .clk(clk), .rst_n(rst_n), .load(load), .step(step),
        .last_idx(last_q), .reload_idx(rl_idx_q), .reload_cnt(hdr_reload_cnt),
        .cur_idx(cur_idx), .more(more)
    );

    assign rsp_idx = (state_q == ST_CPL_WR) ? pend_idx_q : cur_idx;

    tq_addr_gen #(.AW(AW), .IDX_W(IDX_W)) u_addr (
        .base(base_q), .size_code(code_q), .last_idx(last_q),
        .rec_idx(cur_idx), .rsp_idx(rsp_idx),
        .rec_addr(rec_addr), .rsp_addr(rsp_addr)
    );

    assign fifo_push = (state_q == ST_ISSUE) && tr_ready;
    assign fifo_pop  = cpl_valid && cpl_ready;

    tq_tag_fifo #(.W(TAG_W), .DEPTH(OUT_DEPTH)) u_tags (
        .clk(clk), .rst_n(rst_n),
        .push(fifo_push), .din({cur_idx, flags_q[FLG_CMD_LSB +: 8]}),
        .pop(fifo_pop), .dout(fifo_dout),
        .empty(fifo_empty), .full(fifo_full)
    );

    // record screening: unsupported type is reported ahead of a zero count
    always_comb begin
        type_bad = !TYPE_MASK[flags_q[3:0]];
        cnt_zero = (icnt_q == 16'h0000);
        rej_stat = type_bad ? {4'h0, RSP_UNSUP} : {4'h0, RSP_SUBMIT};
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start) state_d = ST_GATE;
            ST_GATE: begin
                if (pend_q)                                        state_d = ST_CPL_WR;
                else if (!(hold_wait_q && !fifo_empty) && !fifo_full) state_d = ST_RD_FLAGS;
            end
            ST_RD_FLAGS: if (mem_gnt) state_d = ST_RD_CNT;
            ST_RD_CNT:   if (mem_gnt) state_d = ST_CHECK;
            ST_CHECK:    state_d = (type_bad || cnt_zero) ? ST_REJ_WR : ST_ISSUE;
            ST_ISSUE:    if (tr_ready) state_d = ST_STEP;
            ST_REJ_WR:   if (mem_gnt) state_d = ST_STEP;
            ST_STEP:     state_d = more ? ST_GATE : ST_DRAIN;
            ST_CPL_WR:   if (mem_gnt) state_d = drain_q ? ST_DRAIN : ST_GATE;
            ST_DRAIN: begin
                if (pend_q)          state_d = ST_CPL_WR;
                else if (fifo_empty) state_d = ST_DONE;
            end
            ST_DONE:     state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q      <= '0;
            code_q      <= '0;
            last_q      <= '0;
            rl_idx_q    <= '0;
            flags_q     <= '0;
            icnt_q      <= '0;
            hold_wait_q <= 1'b0;
            pend_q      <= 1'b0;
            pend_stat_q <= '0;
            pend_idx_q  <= '0;
            pend_cmd_q  <= '0;
            err_q       <= 1'b0;
            drain_q     <= 1'b0;
        end else begin
            if (load) begin
                base_q      <= desc_base;
                code_q      <= hdr_rec_size;
                last_q      <= hdr_last_idx;
                rl_idx_q    <= hdr_reload_idx;
                err_q       <= 1'b0;
                drain_q     <= 1'b0;
                hold_wait_q <= 1'b0;
            end
            if (state_q == ST_RD_FLAGS && mem_gnt) flags_q <= mem_rdata;
            if (state_q == ST_RD_CNT && mem_gnt)   icnt_q  <= mem_rdata[15:0];
            if (fifo_push) hold_wait_q <= flags_q[FLG_WAIT_BIT];
            if (fifo_pop) begin
                pend_q      <= 1'b1;
                pend_stat_q <= cpl_status;
                pend_idx_q  <= fifo_dout[TAG_W-1:8];
                pend_cmd_q  <= fifo_dout[7:0];
            end
            if (state_q == ST_CPL_WR && mem_gnt) begin
                pend_q <= 1'b0;
                if (pend_stat_q[3:0] != RSP_COMPLETE) err_q <= 1'b1;
            end
            if (state_q == ST_REJ_WR && mem_gnt) err_q <= 1'b1;
            if (step && !more) drain_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = rec_addr;
        mem_wdata = '0;
        tr_valid  = 1'b0;
        done      = 1'b0;
        done_err  = 1'b0;
        cpl_ready = !pend_q && !fifo_empty;
        tr_addr   = rec_addr;
        tr_flags  = flags_q;
        tr_icnt0  = icnt_q;
        tr_idx    = cur_idx;
        unique case (state_q)
            ST_RD_FLAGS: mem_req = 1'b1;
            ST_RD_CNT: begin
                mem_req  = 1'b1;
                mem_addr = rec_addr + AW'(4);
            end
            ST_REJ_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = rsp_addr;
                mem_wdata = rsp_word(flags_q[FLG_CMD_LSB +: 8], rej_stat);
            end
            ST_CPL_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = rsp_addr;
                mem_wdata = rsp_word(pend_cmd_q, pend_stat_q);
            end
            ST_ISSUE: tr_valid = 1'b1;
            ST_DONE: begin
                done     = 1'b1;
                done_err = err_q;
            end
            default: ;
        endcase
    end

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R2

    AST_TR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tr_valid && !tr_ready) |=> (tr_valid && $stable(tr_idx) && $stable(tr_flags))); // R2

    AST_ISSUE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        tr_valid |-> (tr_icnt0 != 16'h0000)); // R7

    AST_ISSUE_TYPE_OK: assert property (@(posedge clk) disable iff (!rst_n)
        tr_valid |-> TYPE_MASK[tr_flags[3:0]]); // R6

    AST_WAIT_RULE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tr_valid) |-> !(hold_wait_q && !fifo_empty)); // R8

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10

    AST_DONE_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (fifo_empty && !pend_q)); // R10
endmodule

// File: tb/tq_seq_test.sv
module tq_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW    = 32;
    localparam int DEPTH = 4;
    localparam logic [31:0] BASE = 32'h0000_0400;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] desc_base = BASE;
    logic [13:0] hdr_last_idx = '0;
    logic [5:0]  hdr_reload_idx = '0;
    logic [8:0]  hdr_reload_cnt = '0;
    logic [2:0]  hdr_rec_size = '0;
    logic        mem_req, mem_we, mem_gnt = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
    logic        tr_valid, tr_ready = 1'b0;
    logic [31:0] tr_addr, tr_flags;
    logic [15:0] tr_icnt0;
    logic [13:0] tr_idx;
    logic        cpl_valid = 1'b0, cpl_ready;
    logic [7:0]  cpl_status = '0;
    logic        done, done_err;

    tq_seq #(.AW(AW), .OUT_DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .desc_base(desc_base),
        .hdr_last_idx(hdr_last_idx), .hdr_reload_idx(hdr_reload_idx),
        .hdr_reload_cnt(hdr_reload_cnt), .hdr_rec_size(hdr_rec_size),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
        .tr_valid(tr_valid), .tr_ready(tr_ready), .tr_addr(tr_addr), .tr_flags(tr_flags),
        .tr_icnt0(tr_icnt0), .tr_idx(tr_idx),
        .cpl_valid(cpl_valid), .cpl_ready(cpl_ready), .cpl_status(cpl_status),
        .done(done), .done_err(done_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, errors = 0;
    logic [31:0] mem [0:1023];

    // scenario and expectation state
    int s_num, s_last, s_rl, s_cnt, s_code, s_size, s_cap;
    int n_iss;
    int iss_idx [0:127];
    logic [31:0] exp_rsp [0:15];
    logic exp_err;

    // model state
    int iss_ptr = 0, eng_cnt = 0, eng_head = 0, eng_tail = 0, tick = 0;
    logic [7:0] eng_q [0:7];
    logic last_wait = 1'b0;
    int done_cnt = 0;
    logic done_err_seen = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] rec_flags(input int s, input int i);
        logic [3:0] ty;
        logic       wt;
        logic [7:0] cmd;
        ty  = (((s + i) % 5) == 2) ? 4'd7 : 4'(i % 4);
        wt  = (((s + i) % 3) == 0);
        cmd = 8'((s * 16 + i * 3 + 1) & 255);
        return {8'h00, cmd, 8'h00, 2'b00, wt, 1'b0, ty};
    endfunction

    function automatic logic [15:0] rec_icnt(input int s, input int i);
        return (((s * 3 + i) % 6) == 4) ? 16'h0000 : 16'(16 + i);
    endfunction

    function automatic logic [7:0] eng_stat(input int k);
        if ((k % 4) == 1) return 8'h21;
        if ((k % 6) == 4) return 8'h02;
        return 8'h00;
    endfunction

    function automatic int size_of(input int code);
        return (code > 3) ? 128 : (16 << code);
    endfunction

    task automatic build_expect();
        int idx, left, nv;
        logic [31:0] f;
        logic [7:0]  st;
        idx = 0; left = s_cnt; nv = 0; n_iss = 0; exp_err = 1'b0;
        for (int i = 0; i < 16; i++) exp_rsp[i] = 32'h0;
        while (nv < s_cap) begin
            f = rec_flags(s_num, idx);
            if (f[3:0] > 4'd3)                      st = 8'h04;
            else if (rec_icnt(s_num, idx) == 16'h0) st = 8'h03;
            else begin
                st = eng_stat(n_iss);
                iss_idx[n_iss] = idx;
                n_iss++;
            end
            if (idx < 16) exp_rsp[idx] = {8'h00, f[23:16], 8'h00, st};
            if (st[3:0] != 4'h0) exp_err = 1'b1;
            nv++;
            if (idx == s_last) begin
                if (left == 0) break;
                idx = s_rl;
                if (left != 511) left--;
            end else idx++;
        end
    endtask

    task automatic load_mem();
        for (int w = 0; w < 1024; w++) mem[w] = 32'h0;
        for (int i = 0; i <= s_last; i++) begin
            int a;
            a = int'(BASE) + (i + 1) * s_size;
            mem[a / 4]     = rec_flags(s_num, i);
            mem[a / 4 + 1] = {16'hBEEF, rec_icnt(s_num, i)};
        end
    endtask

    // memory, engine and completion models
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_gnt <= 1'b0; tr_ready <= 1'b0; cpl_valid <= 1'b0;
        end else begin
            // memory
            if (mem_req && (tick % 3) != 1) begin
                mem_gnt <= 1'b1;
                if (mem_we) mem[mem_addr[11:2]] = mem_wdata;
                else        mem_rdata <= mem[mem_addr[11:2]];
            end else begin
                mem_gnt <= 1'b0;
            end
            // engine accept
            if (tr_valid && iss_ptr < n_iss && (tick % 4) != 2) begin
                tr_ready <= 1'b1;
                chk(tr_idx == 14'(iss_idx[iss_ptr]), "R4 issue order", 32'(tr_idx), iss_idx[iss_ptr]);
                chk(tr_addr == BASE + 32'((iss_idx[iss_ptr] + 1) * s_size), "R2 record address",
                    tr_addr, BASE + 32'((iss_idx[iss_ptr] + 1) * s_size));
                chk(tr_flags == rec_flags(s_num, iss_idx[iss_ptr]), "R2 flags", tr_flags,
                    rec_flags(s_num, iss_idx[iss_ptr]));
                chk(tr_icnt0 == rec_icnt(s_num, iss_idx[iss_ptr]), "R2 count", 32'(tr_icnt0),
                    32'(rec_icnt(s_num, iss_idx[iss_ptr])));
                chk(!(last_wait && eng_cnt != 0), "R8 wait flag honoured", eng_cnt, 0);
                chk(eng_cnt < DEPTH, "R9 outstanding limit", eng_cnt, DEPTH - 1);
                eng_q[eng_tail] = eng_stat(iss_ptr);
                eng_tail = (eng_tail + 1) % 8;
                eng_cnt++;
                last_wait = tr_flags[5];
                iss_ptr++;
            end else begin
                tr_ready <= 1'b0;
            end
            // completion
            if (eng_cnt > 0 && (tick % 5) != 3) begin
                cpl_valid  <= 1'b1;
                cpl_status <= eng_q[eng_head];
                if (cpl_ready) begin
                    eng_head = (eng_head + 1) % 8;
                    eng_cnt--;
                end
            end else begin
                cpl_valid <= 1'b0;
            end
            if (done) begin
                done_cnt++;
                done_err_seen = done_err;
            end
            tick++;
        end
    end

    task automatic reset_models();
        iss_ptr = 0; eng_cnt = 0; eng_head = 0; eng_tail = 0;
        last_wait = 1'b0; done_cnt = 0; done_err_seen = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        reset_models();
        rst_n = 1'b1;
        @(negedge clk);
        chk(!tr_valid && !mem_req && !done && !cpl_ready, "R1 reset state",
            {28'h0, tr_valid, mem_req, done, cpl_ready}, 32'h0);
    endtask

    task automatic run_scenario(input int sn, input int last, input int rl, input int cnt, input int code);
        int waitc;
        int ra;
        s_num = sn; s_last = last; s_rl = rl; s_cnt = cnt; s_code = code;
        s_size = size_of(code);
        s_cap = (cnt == 511) ? 48 : 128;
        build_expect();
        load_mem();
        reset_models();
        hdr_last_idx = 14'(last); hdr_reload_idx = 6'(rl);
        hdr_reload_cnt = 9'(cnt); hdr_rec_size = 3'(code);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        // R11: a second start with a different header during the walk
        repeat (2) @(negedge clk);
        hdr_last_idx = 14'd9; hdr_reload_idx = 6'd3; hdr_reload_cnt = 9'd5; hdr_rec_size = 3'd1;
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        waitc = 0;
        if (cnt == 511) begin
            while (iss_ptr < n_iss && waitc < 20000) begin @(negedge clk); waitc++; end
            repeat (20) @(negedge clk);
            chk(iss_ptr == n_iss, "R5 endless walk keeps issuing", iss_ptr, n_iss);
            chk(done_cnt == 0, "R5 no done while endless", done_cnt, 0);
            do_reset();
        end else begin
            while (done_cnt == 0 && waitc < 20000) begin @(negedge clk); waitc++; end
            chk(done_cnt == 1, "R10 done seen", done_cnt, 1);
            repeat (6) @(negedge clk);
            chk(done_cnt == 1, "R11 restart ignored, one done", done_cnt, 1);
            chk(iss_ptr == n_iss, "R4 issue count", iss_ptr, n_iss);
            chk(done_err_seen == exp_err, "R10 error summary", 32'(done_err_seen), 32'(exp_err));
            for (int i = 0; i <= last; i++) begin
                ra = int'(BASE) + (last + 2) * s_size + 4 * i;
                chk(mem[ra / 4] == exp_rsp[i], "R3 R6 R7 R9 response word", mem[ra / 4], exp_rsp[i]);
            end
        end
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        int sn;
        sn = 0;
        do_reset();
        for (int last = 0; last <= 3; last++)
            for (int rl = 0; rl <= last; rl++)
                for (int ci = 0; ci < 3; ci++) begin
                    run_scenario(sn, last, rl, (ci == 0) ? 0 : (ci == 1) ? 1 : 3, sn % 6);
                    sn++;
                end
        run_scenario(sn, 2, 1, 511, 1);
        sn++;
        run_scenario(sn, 3, 0, 511, 3);
        sn++;
        run_scenario(sn, 3, 2, 2, 7);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule